// File: doc/BRIEF.md
# Prefix-Routed Packet Splitter

This block sits between a 32-bit packet source and two downstream packet ports. In its normal mode every incoming packet begins with a 64-bit addressing prefix made of two 32-bit beats. The first beat is a selector word that names the target port. The second beat is a reserved word that must be zero. The block reads the prefix, drops it from the stream, and passes the rest of the packet to the chosen port bit for bit. Payload bytes are never modified, so any checksum they carry stays valid.

All three interfaces are valid/ready streams with start-of-packet and end-of-packet flags. The forwarding path has no pipeline stage. Output data and flags come straight from the input. Input ready follows the ready of the selected port. A bad prefix makes the block discard the packet and bump a saturating error counter. A packet too short to hold a full prefix is discarded without being counted.

When prefix handling is switched off, packets carry no prefix and all of them go to a default port set by a configuration input. Both configuration inputs are read only when a packet starts.

Top module: `pkt_prefix_demux`

## Requirements
- R1: After reset, neither output port is valid, `in_ready` is high and `err_count` is zero.
- R2: With `cfg_prefix_en`=1, the first beat of a packet is the selector word. The second beat is the reserved word. A selector of 0x00000000 routes the packet to port 0 and 0x00000001 routes it to port 1.
- R3: The two prefix beats never appear on either output. Every payload beat is presented unchanged on the selected port only. `sop` is set on the first payload beat, and `eop` is copied from the input.
- R4: A payload of exactly one beat appears on the selected port with both `sop` and `eop` set on that beat.
- R5: A packet is dropped whole, with no output beat, and `err_count` rises by one when either of these holds: any selector bit other than bit 0 is set, or the reserved word is nonzero.
- R6: A packet whose `eop` comes on its first or second beat in prefix mode produces no output and leaves `err_count` unchanged.
- R7: While payload is being forwarded, `in_ready` equals the ready of the selected port. No beat is lost or duplicated under backpressure.
- R8: With `cfg_prefix_en`=0, every beat of a packet, including its first, goes to the port named by `cfg_default_port` (0 or 1).
- R9: The destination and mode are latched at the start of a packet. Changes to `cfg_prefix_en` or `cfg_default_port` before its `eop` do not redirect the rest of that packet.
- R10: `err_count` saturates at its all-ones value (15 when ERR_W=4).
- R11: While no packet is in progress, an input beat without `sop` is accepted and discarded with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prefix_en | input | 1 | 1: packets carry the 64-bit prefix; 0: bypass mode |
| cfg_default_port | input | 1 | Target port in bypass mode |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat |
| in_sop | input | 1 | First beat of an input packet |
| in_eop | input | 1 | Last beat of an input packet |
| out0_valid | output | 1 | Port 0 beat valid |
| out0_ready | input | 1 | Port 0 can take a beat |
| out0_data | output | DATA_W | Port 0 beat |
| out0_sop | output | 1 | Port 0 first beat |
| out0_eop | output | 1 | Port 0 last beat |
| out1_valid | output | 1 | Port 1 beat valid |
| out1_ready | input | 1 | Port 1 can take a beat |
| out1_data | output | DATA_W | Port 1 beat |
| out1_sop | output | 1 | Port 1 first beat |
| out1_eop | output | 1 | Port 1 last beat |
| err_count | output | ERR_W | Saturating count of packets with a bad prefix |

## Verification
A wrong state shows up at the ports within one beat, because the forwarding path has no pipeline. If the parse state is off by one, a prefix word leaks onto an output, or the first payload beat disappears. Either way the port's beat sequence differs from the expected payload on that same packet. A stale latched destination sends the next beats to the wrong port, or raises both valids at once. A misjudged drop shows up as a missing packet together with an `err_count` off by one. A stuck ready shows up as a lost or repeated beat in the first backpressured cycle.

// File: rtl/pkt_prefix_demux.sv
module pkt_prefix_demux #(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_prefix_en,
  input  logic              cfg_default_port,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out0_valid,
  input  logic              out0_ready,
  output logic [DATA_W-1:0] out0_data,
  output logic              out0_sop,
  output logic              out0_eop,
  output logic              out1_valid,
  input  logic              out1_ready,
  output logic [DATA_W-1:0] out1_data,
  output logic              out1_sop,
  output logic              out1_eop,
  output logic [ERR_W-1:0]  err_count
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RSV, S_PAY, S_DROP} st_t;

  st_t  st_q;
  logic dest_q, bad_q, first_q;

  logic byp_start, fwd, dest, sel_rdy, in_fire, hdr_bad, out_sop;

  assign byp_start = (st_q == S_IDLE) && !cfg_prefix_en && in_sop;
  assign fwd       = (st_q == S_PAY) || byp_start;
  assign dest      = (st_q == S_IDLE) ? cfg_default_port : dest_q;
  assign sel_rdy   = dest ? out1_ready : out0_ready;
  assign in_ready  = fwd ? sel_rdy : 1'b1;
  assign in_fire   = in_valid && in_ready;
  assign hdr_bad   = in_data[DATA_W-1:1] != '0;
  assign out_sop   = byp_start || first_q;

  assign out0_valid = fwd && !dest && in_valid;
  assign out1_valid = fwd &&  dest && in_valid;
  assign out0_data  = in_data;
  assign out1_data  = in_data;
  assign out0_sop   = out_sop;
  assign out1_sop   = out_sop;
  assign out0_eop   = in_eop;
  assign out1_eop   = in_eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      dest_q    <= 1'b0;
      bad_q     <= 1'b0;
      first_q   <= 1'b0;
      err_count <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (in_fire && in_sop) begin
          if (cfg_prefix_en) begin
            if (!in_eop) begin
              dest_q <= in_data[0];
              bad_q  <= hdr_bad;
              st_q   <= S_RSV;
            end
          end else begin
            dest_q  <= cfg_default_port;
            first_q <= 1'b0;
            if (!in_eop) st_q <= S_PAY;
          end
        end
        S_RSV: if (in_fire) begin
          if (in_eop) begin
            st_q <= S_IDLE;
          end else if (bad_q || in_data != '0) begin
            st_q <= S_DROP;
            if (err_count != ERR_MAX) err_count <= err_count + 1'b1;
          end else begin
            st_q    <= S_PAY;
            first_q <= 1'b1;
          end
        end
        S_PAY: if (in_fire) begin
          first_q <= 1'b0;
          if (in_eop) st_q <= S_IDLE;
        end
        default: if (in_fire && in_eop) st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_prefix_demux_chk.sv
module pkt_prefix_demux_chk #(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out0_valid,
  input logic              out0_ready,
  input logic [DATA_W-1:0] out0_data,
  input logic              out1_valid,
  input logic              out1_ready,
  input logic [DATA_W-1:0] out1_data,
  input logic              out1_eop,
  input logic [ERR_W-1:0]  err_count
);

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(out0_valid && out1_valid));

  p_valid_from_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_valid || out1_valid) |-> in_valid);

  p_data_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_valid |-> out0_data == in_data) and (out1_valid |-> out1_data == in_data));

  p_ready_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_valid |-> in_ready == out0_ready) and (out1_valid |-> in_ready == out1_ready));

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  p_dest_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out1_valid && out1_ready && !out1_eop) |=> !out0_valid);

endmodule

bind pkt_prefix_demux pkt_prefix_demux_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_data(out0_data),
  .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_data(out1_data),
  .out1_eop(out1_eop), .err_count(err_count)
);

// File: tb/pkt_prefix_demux_test.sv
`timescale 1ns/1ps
module pkt_prefix_demux_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_prefix_en = 1'b1, cfg_default_port = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready;
  logic out0_valid, out0_sop, out0_eop, out1_valid, out1_sop, out1_eop;
  logic out0_ready = 1'b1, out1_ready = 1'b1;
  logic [31:0] out0_data, out1_data;
  logic [3:0] err_count;

  int checks = 0, errors = 0;
  logic [33:0] exp0[$], exp1[$], got0[$], got1[$];
  bit bp_on = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pkt_prefix_demux #(.DATA_W(32), .ERR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_prefix_en(cfg_prefix_en), .cfg_default_port(cfg_default_port),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_data(out0_data),
    .out0_sop(out0_sop), .out0_eop(out0_eop),
    .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_data(out1_data),
    .out1_sop(out1_sop), .out1_eop(out1_eop), .err_count(err_count)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bp_on) out1_ready = (cyc % 3) != 1;
  end

  always @(negedge clk) begin
    #3;
    if (out0_valid && out0_ready) got0.push_back({out0_sop, out0_eop, out0_data});
    if (out1_valid && out1_ready) got1.push_back({out1_sop, out1_eop, out1_data});
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(logic [31:0] d, logic s, logic e);
    bit ok;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    do begin
      #3; ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic pkt_pfx(logic [31:0] sel, logic [31:0] rsv, int n, logic [31:0] base, int port);
    beat(sel, 1'b1, 1'b0);
    beat(rsv, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      beat(base + i, 1'b0, i == n - 1);
      if (port == 0) exp0.push_back({i == 0, i == n - 1, base + i});
      if (port == 1) exp1.push_back({i == 0, i == n - 1, base + 32'(i)});
    end
  endtask

  task automatic pkt_byp(int n, logic [31:0] base, int port);
    for (int i = 0; i < n; i++) begin
      beat(base + i, i == 0, i == n - 1);
      if (port == 0) exp0.push_back({i == 0, i == n - 1, base + i});
      else exp1.push_back({i == 0, i == n - 1, base + 32'(i)});
    end
  endtask

  task automatic compare(string req);
    repeat (2) @(negedge clk);
    chk({req, " port0 beat count"}, got0.size(), exp0.size());
    chk({req, " port1 beat count"}, got1.size(), exp1.size());
    for (int i = 0; i < exp0.size() && i < got0.size(); i++) chk({req, " port0 beat"}, got0[i], exp0[i]);
    for (int i = 0; i < exp1.size() && i < got1.size(); i++) chk({req, " port1 beat"}, got1[i], exp1[i]);
    exp0.delete(); exp1.delete(); got0.delete(); got1.delete();
  endtask

  task automatic t_reset;
    #3;
    chk("R1 out0_valid", out0_valid, 0);
    chk("R1 out1_valid", out1_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 err_count", err_count, 0);
    @(negedge clk);
  endtask

  task automatic t_route;
    pkt_pfx(32'h0, 32'h0, 3, 32'hA000_0000, 0);
    compare("R2 R3 selector 0");
    pkt_pfx(32'h1, 32'h0, 4, 32'hB000_0010, 1);
    compare("R2 R3 selector 1");
  endtask

  task automatic t_single;
    pkt_pfx(32'h1, 32'h0, 1, 32'hC0DE_0001, 1);
    pkt_pfx(32'h0, 32'h0, 1, 32'hC0DE_0002, 0);
    compare("R4 one-beat payload");
  endtask

  task automatic t_bad;
    pkt_pfx(32'h2, 32'h0, 3, 32'hDEAD_0000, -1);
    compare("R5 bad selector");
    chk("R5 err after bad selector", err_count, 1);
    pkt_pfx(32'h1, 32'h0000_0100, 2, 32'hDEAD_1000, -1);
    compare("R5 bad reserved");
    chk("R5 err after bad reserved", err_count, 2);
    pkt_pfx(32'h0, 32'h0, 2, 32'h1234_0000, 0);
    compare("R5 good packet after drops");
  endtask

  task automatic t_short;
    beat(32'h1, 1'b1, 1'b1);
    beat(32'h0, 1'b1, 1'b0);
    beat(32'h0, 1'b0, 1'b1);
    pkt_pfx(32'h1, 32'h0, 2, 32'h5555_0000, 1);
    compare("R6 short packets");
    chk("R6 err unchanged", err_count, 2);
  endtask

  task automatic t_idle_junk;
    beat(32'hFFFF_FFFF, 1'b0, 1'b0);
    beat(32'hEEEE_EEEE, 1'b0, 1'b1);
    pkt_pfx(32'h0, 32'h0, 2, 32'h7700_0000, 0);
    compare("R11 beats without sop");
  endtask

  task automatic t_backpressure;
    out0_ready = 1'b0;
    beat(32'h0, 1'b1, 1'b0);
    beat(32'h0, 1'b0, 1'b0);
    in_valid = 1'b1; in_data = 32'h9900_0000; in_sop = 1'b0; in_eop = 1'b0;
    #3;
    chk("R7 in_ready low with port0 stalled", in_ready, 0);
    chk("R7 out0_valid while stalled", out0_valid, 1);
    @(negedge clk);
    out0_ready = 1'b1;
    beat(32'h9900_0000, 1'b0, 1'b0);
    beat(32'h9900_0001, 1'b0, 1'b1);
    exp0.push_back({2'b10, 32'h9900_0000});
    exp0.push_back({2'b01, 32'h9900_0001});
    compare("R7 stalled packet");
    bp_on = 1;
    pkt_pfx(32'h1, 32'h0, 8, 32'h6600_0000, 1);
    pkt_pfx(32'h1, 32'h0, 5, 32'h6700_0000, 1);
    bp_on = 0;
    out1_ready = 1'b1;
    compare("R7 toggling port1 ready");
  endtask

  task automatic t_bypass;
    cfg_prefix_en = 1'b0;
    cfg_default_port = 1'b1;
    pkt_byp(3, 32'h0000_0001, 1);
    pkt_byp(1, 32'h0000_0002, 1);
    compare("R8 bypass to port1");
    cfg_default_port = 1'b0;
    pkt_byp(4, 32'h0000_0001, 0);
    compare("R8 bypass to port0");
  endtask

  task automatic t_hold;
    cfg_prefix_en = 1'b0;
    cfg_default_port = 1'b0;
    beat(32'h4400_0000, 1'b1, 1'b0);
    cfg_default_port = 1'b1;
    cfg_prefix_en = 1'b1;
    beat(32'h4400_0001, 1'b0, 1'b0);
    beat(32'h4400_0002, 1'b0, 1'b1);
    exp0.push_back({2'b10, 32'h4400_0000});
    exp0.push_back({2'b00, 32'h4400_0001});
    exp0.push_back({2'b01, 32'h4400_0002});
    compare("R9 config change mid-packet");
    cfg_default_port = 1'b0;
    pkt_pfx(32'h0, 32'h0, 2, 32'h4500_0000, 1'b0);
    cfg_prefix_en = 1'b0;
    compare("R9 prefix mode after change");
    cfg_prefix_en = 1'b1;
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 16; i++) pkt_pfx(32'h8000_0000, 32'h0, 1, 32'h0, -1);
    compare("R10 drops");
    chk("R10 err_count saturated", err_count, 15);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_single();
    t_bad();
    t_short();
    t_idle_junk();
    t_backpressure();
    t_bypass();
    t_hold();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule